// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen architectural general registers of a processor core. Each is `DATA_W` bits wide. The physical storage behind an architectural index depends on the 5-bit processor mode presented on `mode`. The shared registers can therefore stay untouched while an exception handler runs on its own stack pointer and link register.

Fast-interrupt mode gets seven private registers, indices 8 to 14. Each of the other four exception modes gets private copies of indices 13 and 14 only. The application mode and the privileged system mode use the same shared set. Any mode encoding that is not recognised falls back to that shared mapping.

The block has the following ports:
- Two combinational read ports.
- One general write port.
- A separate program-counter write path that loads index 15.

A read of index 15 returns the live program-counter value supplied on `pc_in`, not the stored value. Total storage is 31 registers:

| Group | Registers |
|---|---|
| Shared | 16 |
| Fast-interrupt | 7 |
| Each of the four other exception modes | 2 |

Top module: `banked_regfile`

## Requirements
- R1: After reset every stored register reads as zero in every mode, and `pc_q` is zero.
- R2: In application mode (10000), a write through the general port to indices 0 to 14 is returned on both read ports from the next cycle onward.
- R3: A read of the index being written in the same cycle returns the previous content. The new value appears one cycle later.
- R4: In fast-interrupt mode (10001), indices 8 to 14 select private copies. Writes to them leave the application-mode values unchanged.
- R5: In fast-interrupt mode, indices 0 to 7 select the shared registers.
- R6: Each of the modes 10010, 10011, 10111 and 11011 has its own private indices 13 and 14. Indices 0 to 12 are shared in these modes.
- R7: System mode (11111) and application mode select one and the same set of registers for every index.
- R8: Values held in banked copies are retained across any sequence of mode changes.
- R9: An unrecognised mode encoding (for example 00000) maps every index exactly as application mode does.
- R10: A read of index 15 on either port returns `pc_in`. A general-port write to index 15 is ignored and leaves `pc_q` unchanged.
- R11: When `pc_we` is high, `pc_q` takes `pc_wdata` on the next cycle. Otherwise `pc_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 5 | Current processor mode encoding |
| rn_idx | input | 4 | First read port index |
| rn_data | output | DATA_W | First read port data |
| rm_idx | input | 4 | Second read port index |
| rm_data | output | DATA_W | Second read port data |
| rd_we | input | 1 | General write enable |
| rd_idx | input | 4 | General write index |
| rd_data | input | DATA_W | General write data |
| pc_we | input | 1 | Program-counter write enable |
| pc_wdata | input | DATA_W | Program-counter write data |
| pc_in | input | DATA_W | Live program-counter value returned on index-15 reads |
| pc_q | output | DATA_W | Stored program counter |

## Verification
The bench builds the block with the default `DATA_W` of 32. With full 32-bit values it can tell apart data written in different modes, including values with the top bit set. Directed sequences step through every mode, invalid encodings and index 15. A long random phase then switches among all seven modes and stray encodings while writing and reading on every port. This drives banked values through many mode changes, which tests the retention and aliasing behaviour.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int MODE_W     = 5;
  localparam int IDX_W      = 4;
  localparam int ARCH_REGS  = 1 << IDX_W;
  localparam int PC_IDX     = ARCH_REGS - 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  localparam int FIQ_FIRST  = 8;
  localparam int FIQ_SLOTS  = PC_IDX - FIQ_FIRST;      // 7
  localparam int PAIR_FIRST = 13;
  localparam int PAIR_SLOTS = PC_IDX - PAIR_FIRST;     // 2
  localparam int PAIR_MODES = 4;
  localparam int FIQ_BASE   = ARCH_REGS;
  localparam int PAIR_BASE  = FIQ_BASE + FIQ_SLOTS;
  localparam int PHYS_SLOTS = PAIR_BASE + PAIR_MODES * PAIR_SLOTS; // 31
  localparam int SLOT_W     = $clog2(PHYS_SLOTS);

  // Which two-register group a mode owns; valid flag low when none.
  function automatic logic [2:0] pair_group(input logic [MODE_W-1:0] m);
    case (m)
      MODE_IRQ: return 3'b100;
      MODE_SVC: return 3'b101;
      MODE_ABT: return 3'b110;
      MODE_UND: return 3'b111;
      default:  return 3'b000;
    endcase
  endfunction

  // Physical slot chosen by mode and architectural index.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [MODE_W-1:0] m,
                                                input logic [IDX_W-1:0]  idx);
    logic [2:0] grp;
    int         s;
    grp = pair_group(m);
    s   = int'(idx);
    if (m == MODE_FIQ && idx >= FIQ_FIRST[IDX_W-1:0] && idx != PC_IDX[IDX_W-1:0])
      s = FIQ_BASE + int'(idx) - FIQ_FIRST;
    else if (grp[2] && idx >= PAIR_FIRST[IDX_W-1:0] && idx != PC_IDX[IDX_W-1:0])
      s = PAIR_BASE + int'(grp[1:0]) * PAIR_SLOTS + int'(idx) - PAIR_FIRST;
    return s[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot,
  output logic              is_pc
);
  always_comb begin
    slot  = slot_of(mode, idx);
    is_pc = (idx == PC_IDX[IDX_W-1:0]);
  end
endmodule

// File: rtl/regfile_slots.sv
module regfile_slots #(
  parameter int DATA_W  = 32,
  parameter int SLOTS   = 31,
  parameter int SLOT_W  = 5,
  parameter int PC_SLOT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_wdata,
  input  logic [SLOT_W-1:0] rslot_a,
  input  logic [SLOT_W-1:0] rslot_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  output logic [DATA_W-1:0] pc_q
);
  logic [DATA_W-1:0] q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s == PC_SLOT) begin : g_pc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q[s] <= '0;
        else if (pc_we) q[s] <= pc_wdata;
      end
    end else begin : g_gpr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              q[s] <= '0;
        else if (we && wslot == SLOT_W'(s))      q[s] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (rslot_a == SLOT_W'(s)) rdata_a = q[s];
      if (rslot_b == SLOT_W'(s)) rdata_b = q[s];
    end
  end

  assign pc_q = q[PC_SLOT];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode,
  input  logic [3:0]        rn_idx,
  output logic [DATA_W-1:0] rn_data,
  input  logic [3:0]        rm_idx,
  output logic [DATA_W-1:0] rm_data,
  input  logic              rd_we,
  input  logic [3:0]        rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_wdata,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] pc_q
);
  localparam int NRD = 2;

  logic [IDX_W-1:0]  rd_port_idx  [NRD];
  logic [SLOT_W-1:0] rd_port_slot [NRD];
  logic              rd_port_pc   [NRD];
  logic [DATA_W-1:0] rd_port_q    [NRD];
  logic [DATA_W-1:0] rd_port_out  [NRD];

  // Named internal events for the checker
  logic [SLOT_W-1:0] rn_slot;
  logic [SLOT_W-1:0] wr_slot;
  logic              wr_is_pc;
  logic              wr_fire;

  assign rd_port_idx[0] = rn_idx;
  assign rd_port_idx[1] = rm_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    bank_map u_map (
      .mode  (mode),
      .idx   (rd_port_idx[p]),
      .slot  (rd_port_slot[p]),
      .is_pc (rd_port_pc[p])
    );
    assign rd_port_out[p] = rd_port_pc[p] ? pc_in : rd_port_q[p];
  end

  bank_map u_wmap (
    .mode  (mode),
    .idx   (rd_idx),
    .slot  (wr_slot),
    .is_pc (wr_is_pc)
  );

  assign wr_fire = rd_we && !wr_is_pc;
  assign rn_slot = rd_port_slot[0];

  regfile_slots #(
    .DATA_W  (DATA_W),
    .SLOTS   (PHYS_SLOTS),
    .SLOT_W  (SLOT_W),
    .PC_SLOT (PC_IDX)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_fire),
    .wslot    (wr_slot),
    .wdata    (rd_data),
    .pc_we    (pc_we),
    .pc_wdata (pc_wdata),
    .rslot_a  (rd_port_slot[0]),
    .rslot_b  (rd_port_slot[1]),
    .rdata_a  (rd_port_q[0]),
    .rdata_b  (rd_port_q[1]),
    .pc_q     (pc_q)
  );

  assign rn_data = rd_port_out[0];
  assign rm_data = rd_port_out[1];
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode,
  input logic [3:0]        rn_idx,
  input logic [DATA_W-1:0] rn_data,
  input logic [3:0]        rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              pc_we,
  input logic [DATA_W-1:0] pc_wdata,
  input logic [DATA_W-1:0] pc_in,
  input logic [DATA_W-1:0] pc_q,
  input logic [4:0]        rn_slot,
  input logic              wr_fire
);
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> pc_q == $past(pc_wdata)); // R11

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> pc_q == $past(pc_q)); // R10

  AST_PC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rn_idx == 4'd15 |-> rn_data == pc_in); // R10

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (mode != $past(mode) || rn_idx != $past(rd_idx) ||
                 rn_data == $past(rd_data))); // R2

  AST_SHARED_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 5'b10000 || mode == 5'b11111) |-> rn_slot == {1'b0, rn_idx}); // R7

  AST_FIQ_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 5'b10001 && rn_idx >= 4'd8 && rn_idx <= 4'd14) |-> rn_slot >= 5'd16); // R4
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .rn_idx   (rn_idx),
  .rn_data  (rn_data),
  .rd_idx   (rd_idx),
  .rd_data  (rd_data),
  .pc_we    (pc_we),
  .pc_wdata (pc_wdata),
  .pc_in    (pc_in),
  .pc_q     (pc_q),
  .rn_slot  (rn_slot),
  .wr_fire  (wr_fire)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int DW = 32;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    mode = USR;
  logic [3:0]    rn_idx = '0, rm_idx = '0, rd_idx = '0;
  logic [DW-1:0] rn_data, rm_data, pc_q;
  logic          rd_we = 1'b0, pc_we = 1'b0;
  logic [DW-1:0] rd_data = '0, pc_wdata = '0, pc_in = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [DW-1:0] refm [int];
  logic [DW-1:0] ref_pc = '0;

  always #5 clk = ~clk;

  banked_regfile #(.DATA_W(DW)) u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rn_idx(rn_idx), .rn_data(rn_data), .rm_idx(rm_idx), .rm_data(rm_data),
    .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_in(pc_in), .pc_q(pc_q)
  );

  // Owner of an architectural register, written from the requirements.
  function automatic int owner(input logic [4:0] m, input logic [3:0] i);
    int n;
    n = int'(i);
    if (m == FIQ && n >= 8) return 1000 + n;
    if ((m == IRQ || m == SVC || m == ABT || m == UND) && n >= 13)
      return 2000 + 100 * int'(m) + n;
    return n;
  endfunction

  function automatic logic [DW-1:0] expect_rd(input logic [4:0] m, input logic [3:0] i,
                                              input logic [DW-1:0] pin);
    int k;
    if (i == 4'd15) return pin;
    k = owner(m, i);
    if (refm.exists(k)) return refm[k];
    return '0;
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp_v,
                     input string tag, input string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  task automatic step(input logic [4:0] m, input logic [3:0] a, input logic [3:0] b,
                      input logic we, input logic [3:0] wi, input logic [DW-1:0] wd,
                      input logic pwe, input logic [DW-1:0] pwd,
                      input logic [DW-1:0] pin, input string tag);
    @(negedge clk);
    mode = m; rn_idx = a; rm_idx = b; rd_we = we; rd_idx = wi; rd_data = wd;
    pc_we = pwe; pc_wdata = pwd; pc_in = pin;
    #4;
    chk(rn_data, expect_rd(m, a, pin), tag, "rn_data");
    chk(rm_data, expect_rd(m, b, pin), tag, "rm_data");
    chk(pc_q, ref_pc, tag, "pc_q");
    @(posedge clk);
    if (we && wi != 4'd15) refm[owner(m, wi)] = wd;
    if (pwe) ref_pc = pwd;
  endtask

  task automatic rd(input logic [4:0] m, input logic [3:0] a, input logic [3:0] b,
                    input string tag);
    step(m, a, b, 1'b0, 4'd0, '0, 1'b0, '0, 32'hC0DE_0000, tag);
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic [DW-1:0] d,
                    input string tag);
    step(m, i, i, 1'b1, i, d, 1'b0, '0, 32'hC0DE_0000, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state in several modes
    rd(USR, 4'd0, 4'd14, "R1");
    rd(FIQ, 4'd8, 4'd14, "R1");
    rd(UND, 4'd13, 4'd7, "R1");

    // R2: write then read on both ports
    wr(USR, 4'd3, 32'hA5A5_0003, "R2");
    rd(USR, 4'd3, 4'd3, "R2");
    wr(USR, 4'd14, 32'h8000_000E, "R2");
    wr(USR, 4'd13, 32'h7FFF_FFFD, "R2");
    wr(USR, 4'd8, 32'h0000_0808, "R2");
    rd(USR, 4'd14, 4'd13, "R2");

    // R3: same-cycle read returns old value, next cycle new
    wr(USR, 4'd5, 32'h1111_0005, "R3");
    wr(USR, 4'd5, 32'h2222_0005, "R3");
    rd(USR, 4'd5, 4'd5, "R3");

    // R4 / R5: fast-interrupt banking
    wr(FIQ, 4'd8, 32'hF1F1_0008, "R4");
    wr(FIQ, 4'd14, 32'hF1F1_000E, "R4");
    rd(USR, 4'd8, 4'd14, "R4");
    rd(FIQ, 4'd3, 4'd5, "R5");
    wr(FIQ, 4'd7, 32'hF1F1_0007, "R5");
    rd(USR, 4'd7, 4'd8, "R5");

    // R6: per-mode pairs
    wr(IRQ, 4'd13, 32'h1E01_000D, "R6");
    wr(SVC, 4'd13, 32'h5C01_000D, "R6");
    wr(ABT, 4'd14, 32'hAB01_000E, "R6");
    wr(UND, 4'd14, 32'hDD01_000E, "R6");
    rd(USR, 4'd13, 4'd14, "R6");
    rd(IRQ, 4'd13, 4'd14, "R6");
    rd(SVC, 4'd13, 4'd12, "R6");
    wr(ABT, 4'd12, 32'hAB01_000C, "R6");
    rd(UND, 4'd12, 4'd14, "R6");

    // R7: system and application share
    wr(SYS, 4'd9, 32'h5959_0009, "R7");
    rd(USR, 4'd9, 4'd14, "R7");
    rd(SYS, 4'd13, 4'd14, "R7");

    // R8: retention across mode changes
    rd(FIQ, 4'd8, 4'd14, "R8");
    rd(ABT, 4'd14, 4'd13, "R8");

    // R9: unrecognised encodings follow application mapping
    wr(5'b00000, 4'd13, 32'h0BAD_000D, "R9");
    rd(USR, 4'd13, 4'd8, "R9");
    rd(5'b10100, 4'd8, 4'd14, "R9");

    // R10: index 15 reads pc_in; general write to 15 ignored
    step(USR, 4'd15, 4'd15, 1'b0, 4'd0, '0, 1'b0, '0, 32'h1234_5678, "R10");
    step(FIQ, 4'd15, 4'd8, 1'b1, 4'd15, 32'hDEAD_BEEF, 1'b0, '0, 32'h0000_0040, "R10");
    rd(USR, 4'd15, 4'd0, "R10");

    // R11: program-counter write path
    step(USR, 4'd0, 4'd1, 1'b0, 4'd0, '0, 1'b1, 32'h0000_1000, 32'h0, "R11");
    step(SVC, 4'd15, 4'd1, 1'b0, 4'd0, '0, 1'b1, 32'hFFFF_FFFC, 32'h9, "R11");
    rd(IRQ, 4'd1, 4'd2, "R11");

    // Random phase: mixed modes, writes and pc loads (R8 retention)
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] m;
      int sel;
      sel = $urandom_range(0, 7);
      case (sel)
        0: m = USR; 1: m = FIQ; 2: m = IRQ; 3: m = SVC;
        4: m = ABT; 5: m = UND; 6: m = SYS;
        default: m = 5'($urandom());
      endcase
      step(m, 4'($urandom()), 4'($urandom()), 1'($urandom()), 4'($urandom()),
           $urandom(), ($urandom_range(0, 7) == 0), $urandom(), $urandom(), "R8");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule